// File: doc/BRIEF.md
# Translation Fault Recorder with Pseudo-Random Way Choice

This block sits next to a set-associative translation buffer and captures the facts that software needs to service a translation fault. Each time the fault strobe is high on a clock edge, two registers are written. The victim-select register gets the entry index and the way that software should write. The fault-cause register gets the access type, the faulting virtual page and the current process ID. In the same cycle a 16-bit shift register with parity feedback takes one step, so the next refill chooses a different way.

For a true miss, the way comes from the two low bits of the shift register, as they stood before that fault's step. For a protection fault, the way is the one that matched, so software overwrites that entry. Software reads either register through a one-bit-addressed read port. The buffer storage and the exception dispatch sit outside this block.

Top module: `frv_fault_rec`

## Requirements
- R1: After reset, `lfsr_o` is 0xCCCC, `victim_sel_o` is 0 and `fault_cause_o` equals the parameter `CAUSE_RST`.
- R2: One step of the shift register gives new state = {parity(old & 0x8805), old[15:1]}. This is a shift right with the parity bit entering at bit 15.
- R3: The shift register takes exactly one step on every clock edge where `flt_stb` is high. This holds for misses (`flt_miss`=1) and for protection faults (`flt_miss`=0). It does not step on any other edge.
- R4: On a miss, bits 5:4 of `victim_sel_o` become bits 1:0 of `lfsr_o` as they were before that edge.
- R5: On a protection fault, bits 5:4 of `victim_sel_o` become `flt_way`.
- R6: On any fault, bits 3:0 of `victim_sel_o` become `flt_vpn[3:0]`, and all bits above bit 5 become 0.
- R7: On any fault, `fault_cause_o` takes `flt_pid` in bits 7:0, `flt_acc` in bits 9:8 and `flt_vpn` in bits 31:13.
- R8: Bits 12:10 of `fault_cause_o` are never changed by a fault. They keep their previous value.
- R9: While `flt_stb` is low, `victim_sel_o`, `fault_cause_o` and `lfsr_o` hold their values, whatever the other inputs do.
- R10: `rd_data` shows `victim_sel_o` when `rd_addr`=0 and `fault_cause_o` when `rd_addr`=1. It is combinational, so in the cycle a fault is written it still shows the value from before that edge.
- R11: Access type codes are stored unchanged: 0 for read, 1 for write, 2 for execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_stb | input | 1 | Fault strobe, one fault is recorded per high cycle |
| flt_miss | input | 1 | 1 = no way matched (refill), 0 = protection fault |
| flt_way | input | 2 | Way that matched, used for protection faults |
| flt_vpn | input | 19 | Faulting virtual page number |
| flt_acc | input | 2 | Access type code |
| flt_pid | input | 8 | Current process ID |
| rd_addr | input | 1 | Read port select: 0 = victim select, 1 = cause |
| rd_data | output | 32 | Read port data |
| victim_sel_o | output | 32 | Victim-select register |
| fault_cause_o | output | 32 | Fault-cause register |
| lfsr_o | output | 16 | Shift register state |

## Verification
On a fault edge, two things happen at once: the way choice is made and the shift register steps. The way must use the state from before the step. The bench drives back-to-back miss strobes so that every edge both chooses and steps, and compares each way against a reference sequence computed in the bench. The register write and a software read can also meet in one cycle. While the strobe is high, the bench samples the read port ahead of the edge and expects the old contents, then expects the new contents after the edge.

// File: rtl/frv_pkg.sv
package frv_pkg;
   localparam int ACC_W = 2;

   typedef enum logic [ACC_W-1:0] {
      ACC_RD = 2'd0,
      ACC_WR = 2'd1,
      ACC_EX = 2'd2
   } acc_e;

   localparam logic RD_SEL   = 1'b0;
   localparam logic RD_CAUSE = 1'b1;
endpackage

// File: rtl/frv_lfsr.sv
module frv_lfsr #(
   parameter int          W     = 16,
   parameter logic [W-1:0] TAPS = 16'h8805,
   parameter logic [W-1:0] SEED = 16'hCCCC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] state
);
   generate
      if (W < 2) begin : g_bad_w
         $error("frv_lfsr: W must be at least 2");
      end
      if (TAPS == '0) begin : g_bad_taps
         $error("frv_lfsr: TAPS must not be zero");
      end
   endgenerate

   logic [W-1:0] tapped;
   logic         fb;

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (TAPS[i]) begin : g_on
         assign tapped[i] = state[i];
      end else begin : g_off
         assign tapped[i] = 1'b0;
      end
   end

   assign fb = ^tapped;

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= SEED;
      else if (step)
         state <= {fb, state[W-1:1]};
   end
endmodule

// File: rtl/frv_sel_pack.sv
module frv_sel_pack #(
   parameter int IDX_W = 4,
   parameter int WAY_W = 2,
   parameter int REG_W = 32
) (
   input  logic             miss,
   input  logic [WAY_W-1:0] rnd_way,
   input  logic [WAY_W-1:0] hit_way,
   input  logic [IDX_W-1:0] idx,
   output logic [REG_W-1:0] sel_next
);
   localparam int USED_W = IDX_W + WAY_W;

   generate
      if (USED_W > REG_W) begin : g_bad_w
         $error("frv_sel_pack: index and way do not fit the register");
      end
   endgenerate

   logic [WAY_W-1:0] way;
   assign way = miss ? rnd_way : hit_way;

   generate
      if (USED_W < REG_W) begin : g_pad
         assign sel_next = {{(REG_W-USED_W){1'b0}}, way, idx};
      end else begin : g_full
         assign sel_next = {way, idx};
      end
   endgenerate
endmodule

// File: rtl/frv_cause_reg.sv
module frv_cause_reg #(
   parameter int             REG_W   = 32,
   parameter int             PID_W   = 8,
   parameter int             ACC_W   = 2,
   parameter int             VPN_W   = 19,
   parameter int             PID_LSB = 0,
   parameter int             ACC_LSB = 8,
   parameter int             VPN_LSB = 13,
   parameter logic [REG_W-1:0] RST  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PID_W-1:0] pid,
   input  logic [ACC_W-1:0] acc,
   input  logic [VPN_W-1:0] vpn,
   output logic [REG_W-1:0] q
);
   localparam int PID_MSB = PID_LSB + PID_W - 1;
   localparam int ACC_MSB = ACC_LSB + ACC_W - 1;
   localparam int VPN_MSB = VPN_LSB + VPN_W - 1;

   generate
      if (PID_MSB >= REG_W || ACC_MSB >= REG_W || VPN_MSB >= REG_W) begin : g_bad_fit
         $error("frv_cause_reg: a field runs past the register");
      end
      if (!(PID_MSB < ACC_LSB && ACC_MSB < VPN_LSB)) begin : g_bad_order
         $error("frv_cause_reg: fields must be ordered and disjoint");
      end
   endgenerate

   logic [REG_W-1:0] d;

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (b >= PID_LSB && b <= PID_MSB) begin : g_pid
         assign d[b] = pid[b-PID_LSB];
      end else if (b >= ACC_LSB && b <= ACC_MSB) begin : g_acc
         assign d[b] = acc[b-ACC_LSB];
      end else if (b >= VPN_LSB && b <= VPN_MSB) begin : g_vpn
         assign d[b] = vpn[b-VPN_LSB];
      end else begin : g_keep
         assign d[b] = q[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= RST;
      else if (we)
         q <= d;
   end
endmodule

// File: rtl/frv_fault_rec.sv
module frv_fault_rec #(
   parameter int                 VPN_W     = 19,
   parameter int                 PID_W     = 8,
   parameter int                 IDX_W     = 4,
   parameter int                 WAY_W     = 2,
   parameter int                 REG_W     = 32,
   parameter int                 LFSR_W    = 16,
   parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'h8805,
   parameter logic [LFSR_W-1:0]  LFSR_SEED = 16'hCCCC,
   parameter int                 PID_LSB   = 0,
   parameter int                 ACC_LSB   = 8,
   parameter int                 VPN_LSB   = 13,
   parameter logic [REG_W-1:0]   CAUSE_RST = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flt_stb,
   input  logic                       flt_miss,
   input  logic [WAY_W-1:0]           flt_way,
   input  logic [VPN_W-1:0]           flt_vpn,
   input  logic [frv_pkg::ACC_W-1:0]  flt_acc,
   input  logic [PID_W-1:0]           flt_pid,
   input  logic                       rd_addr,
   output logic [REG_W-1:0]           rd_data,
   output logic [REG_W-1:0]           victim_sel_o,
   output logic [REG_W-1:0]           fault_cause_o,
   output logic [LFSR_W-1:0]          lfsr_o
);
   import frv_pkg::*;

   generate
      if (IDX_W > VPN_W) begin : g_bad_idx
         $error("frv_fault_rec: index wider than page number");
      end
      if (WAY_W > LFSR_W) begin : g_bad_way
         $error("frv_fault_rec: way wider than shift register");
      end
   endgenerate

   logic [REG_W-1:0] sel_next;

   frv_lfsr #(
      .W    (LFSR_W),
      .TAPS (LFSR_TAPS),
      .SEED (LFSR_SEED)
   ) lfsr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (flt_stb),
      .state (lfsr_o)
   );

   frv_sel_pack #(
      .IDX_W (IDX_W),
      .WAY_W (WAY_W),
      .REG_W (REG_W)
   ) sel_pack_i (
      .miss     (flt_miss),
      .rnd_way  (lfsr_o[WAY_W-1:0]),
      .hit_way  (flt_way),
      .idx      (flt_vpn[IDX_W-1:0]),
      .sel_next (sel_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         victim_sel_o <= '0;
      else if (flt_stb)
         victim_sel_o <= sel_next;
   end

   frv_cause_reg #(
      .REG_W   (REG_W),
      .PID_W   (PID_W),
      .ACC_W   (ACC_W),
      .VPN_W   (VPN_W),
      .PID_LSB (PID_LSB),
      .ACC_LSB (ACC_LSB),
      .VPN_LSB (VPN_LSB),
      .RST     (CAUSE_RST)
   ) cause_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (flt_stb),
      .pid   (flt_pid),
      .acc   (flt_acc),
      .vpn   (flt_vpn),
      .q     (fault_cause_o)
   );

   always_comb begin
      unique case (rd_addr)
         RD_CAUSE: rd_data = fault_cause_o;
         default:  rd_data = victim_sel_o;
      endcase
   end
endmodule

// File: rtl/frv_fault_rec_chk.sv
module frv_fault_rec_chk #(
   parameter int                LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h8805,
   parameter int                WAY_W     = 2,
   parameter int                IDX_W     = 4,
   parameter int                REG_W     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flt_stb,
   input logic              flt_miss,
   input logic [WAY_W-1:0]  flt_way,
   input logic [18:0]       flt_vpn,
   input logic [1:0]        flt_acc,
   input logic [7:0]        flt_pid,
   input logic              rd_addr,
   input logic [REG_W-1:0]  rd_data,
   input logic [REG_W-1:0]  victim_sel_o,
   input logic [REG_W-1:0]  fault_cause_o,
   input logic [LFSR_W-1:0] lfsr_o
);
   assert_lfsr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flt_stb |=> lfsr_o == {^($past(lfsr_o) & LFSR_TAPS), $past(lfsr_o[LFSR_W-1:1])});

   assert_lfsr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_stb |=> $stable(lfsr_o));

   assert_miss_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_stb && flt_miss) |=> victim_sel_o[IDX_W +: WAY_W] == $past(lfsr_o[WAY_W-1:0]));

   assert_prot_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_stb && !flt_miss) |=> victim_sel_o[IDX_W +: WAY_W] == $past(flt_way));

   assert_sel_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flt_stb |=> (victim_sel_o[IDX_W-1:0] == $past(flt_vpn[IDX_W-1:0]))
                  && ((victim_sel_o >> (IDX_W + WAY_W)) == '0));

   assert_cause_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flt_stb |=> fault_cause_o[7:0] == $past(flt_pid) && fault_cause_o[9:8] == $past(flt_acc)
                  && fault_cause_o[31:13] == $past(flt_vpn));

   assert_cause_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flt_stb |=> $stable(fault_cause_o[12:10]));

   assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_stb |=> $stable(victim_sel_o) && $stable(fault_cause_o));
endmodule

bind frv_fault_rec frv_fault_rec_chk #(
   .LFSR_W    (LFSR_W),
   .LFSR_TAPS (LFSR_TAPS),
   .WAY_W     (WAY_W),
   .IDX_W     (IDX_W),
   .REG_W     (REG_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .flt_stb       (flt_stb),
   .flt_miss      (flt_miss),
   .flt_way       (flt_way),
   .flt_vpn       (flt_vpn),
   .flt_acc       (flt_acc),
   .flt_pid       (flt_pid),
   .rd_addr       (rd_addr),
   .rd_data       (rd_data),
   .victim_sel_o  (victim_sel_o),
   .fault_cause_o (fault_cause_o),
   .lfsr_o        (lfsr_o)
);

// File: tb/frv_fault_rec_tb.sv
`timescale 1ns/1ps
module frv_fault_rec_tb_top;
   localparam logic [31:0] CRST = 32'h0000_1400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flt_stb = 1'b0;
   logic        flt_miss = 1'b0;
   logic [1:0]  flt_way = '0;
   logic [18:0] flt_vpn = '0;
   logic [1:0]  flt_acc = '0;
   logic [7:0]  flt_pid = '0;
   logic        rd_addr = 1'b0;
   logic [31:0] rd_data, victim_sel_o, fault_cause_o;
   logic [15:0] lfsr_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] m_lfsr;
   logic [31:0] m_sel, m_cause;

   always #2 clk = ~clk;

   frv_fault_rec #(.CAUSE_RST(CRST)) dut_i (
      .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_miss(flt_miss),
      .flt_way(flt_way), .flt_vpn(flt_vpn), .flt_acc(flt_acc), .flt_pid(flt_pid),
      .rd_addr(rd_addr), .rd_data(rd_data), .victim_sel_o(victim_sel_o),
      .fault_cause_o(fault_cause_o), .lfsr_o(lfsr_o)
   );

   function automatic logic [15:0] step_ref(input logic [15:0] s);
      logic p = 1'b0;
      for (int i = 0; i < 16; i++) if ((16'h8805 >> i) & 1) p ^= s[i];
      return {p, s[15:1]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(lfsr_o == m_lfsr, {req, " lfsr"}, {16'h0, lfsr_o}, {16'h0, m_lfsr});
      chk(victim_sel_o == m_sel, {req, " sel"}, victim_sel_o, m_sel);
      chk(fault_cause_o == m_cause, {req, " cause"}, fault_cause_o, m_cause);
   endtask

   // one fault cycle; model updated from the requirements
   task automatic fault(input bit miss, input logic [1:0] way, input logic [18:0] vpn,
                        input logic [1:0] acc, input logic [7:0] pid);
      logic [1:0] w;
      @(negedge clk);
      flt_stb = 1'b1; flt_miss = miss; flt_way = way;
      flt_vpn = vpn; flt_acc = acc; flt_pid = pid;
      w = miss ? m_lfsr[1:0] : way;
      m_sel = {26'h0, w, vpn[3:0]};
      m_cause = {vpn, m_cause[12:10], acc, pid};
      m_lfsr = step_ref(m_lfsr);
      @(negedge clk);
      flt_stb = 1'b0;
   endtask

   task automatic t_reset;
      m_lfsr = 16'hCCCC; m_sel = '0; m_cause = CRST;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");
   endtask

   task automatic t_miss_run;
      for (int k = 0; k < 8; k++) begin
         fault(1'b1, 2'd3, 19'h1234 + 19'(k * 37), frv_pkg::ACC_RD, 8'(k + 5));
         check_all("R2 R3 R4 R6 miss");
      end
   endtask

   task automatic t_prot;
      fault(1'b0, 2'd1, 19'h7ABCD, frv_pkg::ACC_WR, 8'hA5);
      check_all("R3 R5 R7 prot way1");
      fault(1'b0, 2'd2, 19'h0000F, frv_pkg::ACC_EX, 8'h3C);
      check_all("R3 R5 R7 prot way2");
   endtask

   task automatic t_acc;
      fault(1'b1, 2'd0, 19'h55555, frv_pkg::ACC_RD, 8'h01);
      chk(fault_cause_o[9:8] == 2'd0, "R11 read code", {30'h0, fault_cause_o[9:8]}, 32'd0);
      fault(1'b1, 2'd0, 19'h2AAAA, frv_pkg::ACC_WR, 8'hFF);
      chk(fault_cause_o[9:8] == 2'd1, "R11 write code", {30'h0, fault_cause_o[9:8]}, 32'd1);
      fault(1'b0, 2'd3, 19'h7FFFF, frv_pkg::ACC_EX, 8'h80);
      chk(fault_cause_o[9:8] == 2'd2, "R11 exec code", {30'h0, fault_cause_o[9:8]}, 32'd2);
      chk(fault_cause_o[12:10] == 3'b101, "R8 kept bits", {29'h0, fault_cause_o[12:10]}, 32'd5);
      check_all("R7 R8 acc");
   endtask

   task automatic t_hold;
      @(negedge clk);
      flt_miss = 1'b0; flt_way = 2'd2; flt_vpn = 19'h13579;
      flt_acc = 2'd1; flt_pid = 8'h77;
      repeat (5) @(negedge clk);
      check_all("R9 R3 hold");
   endtask

   task automatic t_read;
      logic [31:0] old_sel, old_cause;
      old_sel = m_sel; old_cause = m_cause;
      rd_addr = 1'b0; #1;
      chk(rd_data == m_sel, "R10 read sel", rd_data, m_sel);
      rd_addr = 1'b1; #1;
      chk(rd_data == m_cause, "R10 read cause", rd_data, m_cause);
      // same-cycle write and read
      @(negedge clk);
      flt_stb = 1'b1; flt_miss = 1'b1; flt_vpn = 19'h0BEEF; flt_acc = 2'd2; flt_pid = 8'h42;
      rd_addr = 1'b1; #1;
      chk(rd_data == old_cause, "R10 old cause in write cycle", rd_data, old_cause);
      rd_addr = 1'b0; #1;
      chk(rd_data == old_sel, "R10 old sel in write cycle", rd_data, old_sel);
      m_sel = {26'h0, m_lfsr[1:0], 4'hF};
      m_cause = {19'h0BEEF, m_cause[12:10], 2'd2, 8'h42};
      m_lfsr = step_ref(m_lfsr);
      @(negedge clk);
      flt_stb = 1'b0;
      chk(rd_data == m_sel, "R10 new sel", rd_data, m_sel);
      rd_addr = 1'b1; #1;
      chk(rd_data == m_cause, "R10 new cause", rd_data, m_cause);
      check_all("R10 after");
   endtask

   task automatic t_back_to_back;
      logic [15:0] s;
      @(negedge clk);
      flt_stb = 1'b1; flt_miss = 1'b1; flt_acc = 2'd0; flt_pid = 8'h11;
      for (int k = 0; k < 20; k++) begin
         flt_vpn = 19'(k * 3);
         s = m_lfsr;
         m_sel = {26'h0, s[1:0], 4'(k * 3)};
         m_cause = {19'(k * 3), m_cause[12:10], 2'd0, 8'h11};
         m_lfsr = step_ref(s);
         @(negedge clk);
         check_all("R4 R2 back-to-back");
      end
      flt_stb = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      t_reset();
      t_miss_run();
      t_prot();
      t_acc();
      t_hold();
      t_read();
      t_back_to_back();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule